// File: doc/BRIEF.md
# Three-level space-vector dwell-time calculator

This block turns one sample of a three-level space-vector reference into the three on-times that the modulator applies during that sampling period. The reference arrives already folded into the first 60-degree main sector, as an angle inside that sector and a normalised magnitude factor k. The main sector is split into four small triangles. The triangle that holds the reference selects one of four sets of trigonometric dwell equations. The caller supplies the triangle number, or the block's own region finder derives it from the angle and k.

Sines come from a quarter-wave table that is computed when the design is elaborated, and are refined by linear interpolation. The block is a four-stage pipeline: sine lookup, magnitude scaling with region finding, period scaling, and combine with clamp. It accepts a new sample every clock. Each result is returned as three unsigned cycle counts together with a one-cycle valid strobe.

Top module: `svm_dwell_calc`

## Requirements
- R1: A sample taken on a rising edge with `in_vld` high gives one result, with `out_vld` high in the cycle after the fourth rising edge, counting the capture edge. Samples on consecutive edges give results on consecutive cycles. At all other times `out_vld` is low.
- R2: Encodings are as follows. `theta` code t stands for t·60/1024 degrees. `k_mag` is unsigned with 15 fraction bits, so 32768 means 1.0. `ts` and the outputs are clock-cycle counts. `region` codes 0, 1, 2 and 3 select triangles 1, 2, 3 and 4. For triangle 1 (code 0), ta = 2k·Ts·sin(60°−θ) and tb = Ts·(1 − 2k·sin(θ+60°)), each within 3 counts.
- R3: For triangle 2 (code 1): ta = 2Ts·(1 − k·sin(θ+60°)), tb = 2k·Ts·sinθ and tc = Ts·(2k·sin(60°−θ) − 1).
- R4: For triangle 3 (code 2): ta = Ts·(1 − 2k·sinθ), tb = Ts·(2k·sin(θ+60°) − 1) and tc = Ts·(1 − 2k·sin(60°−θ)).
- R5: For triangle 4 (code 3): ta = Ts·(2k·sinθ − 1), tb = 2k·Ts·sin(60°−θ) and tc = 2Ts·(1 − k·sin(θ+60°)).
- R6: ta and tb are each rounded and limited to the range 0..Ts. tc is Ts − ta − tb, or 0 when that remainder would be negative.
- R7: Whenever ta + tb ≤ Ts, the sum ta + tb + tc equals Ts exactly.
- R8: With `auto_region` high, `region` is ignored and the triangle is chosen in this order. Triangle 1 applies if 2k·sin(θ+60°) ≤ 1. Otherwise triangle 2 applies if 2k·sin(60°−θ) ≥ 1. Otherwise triangle 4 applies if 2k·sinθ ≥ 1. Otherwise triangle 3 applies.
- R9: While `rst_n` is low, `out_vld` is low and `ta`, `tb` and `tc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Sample valid |
| theta | input | ANG_W | Angle within the main sector, full scale 60 degrees |
| k_mag | input | K_W | Magnitude factor, one integer bit and K_W−1 fraction bits |
| ts | input | TS_W | Sampling period in cycles |
| region | input | 2 | Triangle code 0..3 for triangles 1..4 |
| auto_region | input | 1 | Use the internal region finder |
| out_vld | output | 1 | Result valid strobe |
| ta | output | TS_W | First dwell time |
| tb | output | TS_W | Second dwell time |
| tc | output | TS_W | Third dwell time |

## Verification
A corrupted sine table entry or a wrong interpolation offset changes ta and tb only for angles that fall in the affected segment. Such a fault therefore needs stimulus spread across the sector, and it shows as a count error in the strobed result four cycles after the sample. A wrong triangle choice, or a swapped equation set, moves a dwell time by hundreds of counts on the very next result. A broken stage register shows as a strobe that is missing or arrives on the wrong cycle. A fault in the remainder path shows as a sum that differs from Ts even when no clamping applies.

// File: rtl/svm_dwell_pkg.sv
package svm_dwell_pkg;

    typedef enum logic [1:0] {
        RG_1 = 2'd0,
        RG_2 = 2'd1,
        RG_3 = 2'd2,
        RG_4 = 2'd3
    } region_e;

    // sine of table point idx, scaled by 2**frac_w; one step spans 2**seg_sh angle codes
    function automatic int sin_tab_entry(input int idx, input int ang_w,
                                         input int seg_sh, input int frac_w);
        real step;
        real v;
        step = (3.14159265358979 / 3.0) * (2.0 ** seg_sh) / (2.0 ** ang_w);
        v    = $sin(step * $itor(idx)) * (2.0 ** frac_w);
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/svm_sine_lut.sv
module svm_sine_lut #(
    parameter int ANG_W  = 10,
    parameter int SEG_SH = 5,
    parameter int SIN_W  = 16,
    localparam int AIW   = ANG_W + 1
) (
    input  logic [AIW-1:0]   ang,
    output logic [SIN_W-1:0] sin_val
);
    localparam int QTR  = 3 << (ANG_W - 1);
    localparam int NSEG = QTR >> SEG_SH;
    localparam int ONE  = 1 << (SIN_W - 1);

    logic [SIN_W-1:0] tab [0:NSEG+1];

    for (genvar g = 0; g <= NSEG + 1; g++) begin : g_tab
        localparam int ENTRY = svm_dwell_pkg::sin_tab_entry(g, ANG_W, SEG_SH, SIN_W - 1);
        assign tab[g] = SIN_W'(ENTRY);
    end

    int seg_c;
    int frac_c;
    int base_c;
    int next_c;
    int y_c;

    always_comb begin
        seg_c = int'(ang >> SEG_SH);
        if (seg_c > NSEG) begin
            seg_c = NSEG;
        end
        frac_c  = int'(ang[SEG_SH-1:0]);
        base_c  = int'(tab[seg_c]);
        next_c  = int'(tab[seg_c + 1]);
        y_c     = base_c + ((next_c - base_c) * frac_c) / (1 << SEG_SH);
        sin_val = SIN_W'(y_c);
        AST_SINE_MAX: assert (y_c >= 0 && y_c <= ONE)
            else $error("sine out of range %0d", y_c); // R2
    end

endmodule

// File: rtl/svm_region_find.sv
module svm_region_find
    import svm_dwell_pkg::*;
#(
    parameter int K_W = 16
) (
    input  logic [K_W-1:0] m_lo,
    input  logic [K_W-1:0] m_hi,
    input  logic [K_W-1:0] m_sum,
    output region_e        rg
);
    // m values are k*sin with K_W-1 fraction bits; 2*k*sin >= 1 means m >= 0.5
    localparam logic [K_W-1:0] HALF_M = K_W'(1 << (K_W - 2));

    always_comb begin
        if (m_sum <= HALF_M) begin
            rg = RG_1;
        end else if (m_hi >= HALF_M) begin
            rg = RG_2;
        end else if (m_lo >= HALF_M) begin
            rg = RG_4;
        end else begin
            rg = RG_3;
        end
    end

endmodule

// File: rtl/svm_dwell_mix.sv
module svm_dwell_mix
    import svm_dwell_pkg::*;
#(
    parameter int TS_W = 16,
    parameter int DW   = 22,
    parameter int FR   = 4
) (
    input  logic [TS_W-1:0] ts,
    input  logic [DW-1:0]   d_lo,
    input  logic [DW-1:0]   d_hi,
    input  logic [DW-1:0]   d_sum,
    input  region_e         rg,
    output logic [TS_W-1:0] ta,
    output logic [TS_W-1:0] tb,
    output logic [TS_W-1:0] tc
);
    localparam int SW = DW + 3;
    localparam logic signed [SW-1:0] RND = SW'(1 << (FR - 1));

    logic signed [SW-1:0] ts_i;
    logic signed [SW-1:0] ts_f;
    logic signed [SW-1:0] e_lo;
    logic signed [SW-1:0] e_hi;
    logic signed [SW-1:0] e_sum;
    logic signed [SW-1:0] fa;
    logic signed [SW-1:0] fb;
    logic signed [SW-1:0] ra;
    logic signed [SW-1:0] rb;
    logic [TS_W:0]        used;

    always_comb begin
        ts_i  = SW'(ts);
        ts_f  = ts_i <<< FR;
        e_lo  = SW'(d_lo);
        e_hi  = SW'(d_hi);
        e_sum = SW'(d_sum);
        unique case (rg)
            RG_1: begin
                fa = e_hi;
                fb = ts_f - e_sum;
            end
            RG_2: begin
                fa = (ts_f <<< 1) - e_sum;
                fb = e_lo;
            end
            RG_3: begin
                fa = ts_f - e_lo;
                fb = e_sum - ts_f;
            end
            default: begin
                fa = e_lo - ts_f;
                fb = e_hi;
            end
        endcase
        ra = (fa + RND) >>> FR;
        rb = (fb + RND) >>> FR;
        if (ra < 0) begin
            ta = '0;
        end else if (ra > ts_i) begin
            ta = ts;
        end else begin
            ta = ra[TS_W-1:0];
        end
        if (rb < 0) begin
            tb = '0;
        end else if (rb > ts_i) begin
            tb = ts;
        end else begin
            tb = rb[TS_W-1:0];
        end
        used = {1'b0, ta} + {1'b0, tb};
        if (used > {1'b0, ts}) begin
            tc = '0;
        end else begin
            tc = TS_W'({1'b0, ts} - used);
        end
    end

endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc
    import svm_dwell_pkg::*;
#(
    parameter int ANG_W  = 10,
    parameter int K_W    = 16,
    parameter int TS_W   = 16,
    parameter int SIN_W  = 16,
    parameter int SEG_SH = 5,
    parameter int FR     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ANG_W-1:0]  theta,
    input  logic [K_W-1:0]    k_mag,
    input  logic [TS_W-1:0]   ts,
    input  logic [1:0]        region,
    input  logic              auto_region,
    output logic              out_vld,
    output logic [TS_W-1:0]   ta,
    output logic [TS_W-1:0]   tb,
    output logic [TS_W-1:0]   tc
);
    localparam int AIW       = ANG_W + 1;
    localparam int FULL      = 1 << ANG_W;
    localparam int QTR       = 3 << (ANG_W - 1);
    localparam int HALF_TURN = 3 << ANG_W;
    localparam int SHIFT     = K_W - 2 - FR;
    localparam int DW        = TS_W + K_W - SHIFT;
    localparam int LAT       = 4;

    typedef struct packed {
        logic                        vld;
        logic [2:0][SIN_W-1:0]       sn;
        logic [K_W-1:0]              k;
        logic [TS_W-1:0]             ts;
        region_e                     rg;
        logic                        au;
    } st_look_t;

    typedef struct packed {
        logic                        vld;
        logic [2:0][K_W-1:0]         m;
        logic [TS_W-1:0]             ts;
        region_e                     rg;
    } st_mag_t;

    typedef struct packed {
        logic                        vld;
        logic [2:0][DW-1:0]          d;
        logic [TS_W-1:0]             ts;
        region_e                     rg;
    } st_scl_t;

    typedef struct packed {
        logic                        vld;
        logic [TS_W-1:0]             ta;
        logic [TS_W-1:0]             tb;
        logic [TS_W-1:0]             tc;
        logic [TS_W-1:0]             ts;
    } st_out_t;

    typedef struct packed {
        st_look_t lk;
        st_mag_t  mg;
        st_scl_t  sc;
        st_out_t  ot;
    } pipe_t;

    pipe_t state_d;
    pipe_t state_q;

    // angle index per sine term: 0 -> sin(theta), 1 -> sin(60-theta), 2 -> sin(theta+60)
    logic [2:0][AIW-1:0]   ang_c;
    logic [2:0][SIN_W-1:0] sin_c;
    logic [2:0][K_W-1:0]   mag_c;
    logic [2:0][DW-1:0]    scl_c;
    region_e               found_c;
    logic [TS_W-1:0]       mix_ta;
    logic [TS_W-1:0]       mix_tb;
    logic [TS_W-1:0]       mix_tc;

    always_comb begin
        int th;
        int up;
        th       = int'(theta);
        up       = th + FULL;
        ang_c[0] = AIW'(th);
        ang_c[1] = AIW'(FULL - th);
        ang_c[2] = (up > QTR) ? AIW'(HALF_TURN - up) : AIW'(up);
    end

    for (genvar i = 0; i < 3; i++) begin : g_sine
        svm_sine_lut #(
            .ANG_W  (ANG_W),
            .SEG_SH (SEG_SH),
            .SIN_W  (SIN_W)
        ) u_lut (
            .ang     (ang_c[i]),
            .sin_val (sin_c[i])
        );
    end

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            logic [K_W+SIN_W-1:0] p_m;
            logic [TS_W+K_W-1:0]  p_s;
            p_m      = {{SIN_W{1'b0}}, state_q.lk.k} * {{K_W{1'b0}}, state_q.lk.sn[i]};
            mag_c[i] = p_m[SIN_W-1 +: K_W];
            p_s      = {{K_W{1'b0}}, state_q.mg.ts} * {{TS_W{1'b0}}, state_q.mg.m[i]};
            scl_c[i] = p_s[SHIFT +: DW];
        end
    end

    svm_region_find #(
        .K_W (K_W)
    ) u_find (
        .m_lo  (mag_c[0]),
        .m_hi  (mag_c[1]),
        .m_sum (mag_c[2]),
        .rg    (found_c)
    );

    svm_dwell_mix #(
        .TS_W (TS_W),
        .DW   (DW),
        .FR   (FR)
    ) u_mix (
        .ts    (state_q.sc.ts),
        .d_lo  (state_q.sc.d[0]),
        .d_hi  (state_q.sc.d[1]),
        .d_sum (state_q.sc.d[2]),
        .rg    (state_q.sc.rg),
        .ta    (mix_ta),
        .tb    (mix_tb),
        .tc    (mix_tc)
    );

    always_comb begin
        state_d = state_q;

        state_d.lk.vld = in_vld;
        state_d.lk.sn  = sin_c;
        state_d.lk.k   = k_mag;
        state_d.lk.ts  = ts;
        state_d.lk.rg  = region_e'(region);
        state_d.lk.au  = auto_region;

        state_d.mg.vld = state_q.lk.vld;
        state_d.mg.m   = mag_c;
        state_d.mg.ts  = state_q.lk.ts;
        state_d.mg.rg  = state_q.lk.au ? found_c : state_q.lk.rg;

        state_d.sc.vld = state_q.mg.vld;
        state_d.sc.d   = scl_c;
        state_d.sc.ts  = state_q.mg.ts;
        state_d.sc.rg  = state_q.mg.rg;

        state_d.ot.vld = state_q.sc.vld;
        if (state_q.sc.vld) begin
            state_d.ot.ta = mix_ta;
            state_d.ot.tb = mix_tb;
            state_d.ot.tc = mix_tc;
            state_d.ot.ts = state_q.sc.ts;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld = state_q.ot.vld;
    assign ta      = state_q.ot.ta;
    assign tb      = state_q.ot.tb;
    assign tc      = state_q.ot.tc;

    AST_FIXED_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##LAT out_vld) else $error("result strobe missing"); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(in_vld, LAT)) else $error("strobe without sample"); // R1

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (ta <= state_q.ot.ts && tb <= state_q.ot.ts && tc <= state_q.ot.ts))
        else $error("dwell exceeds period"); // R6

    AST_PERIOD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ({1'b0, ta} + {1'b0, tb} <= {1'b0, state_q.ot.ts}))
        |-> ({2'b0, ta} + {2'b0, tb} + {2'b0, tc} == {2'b0, state_q.ot.ts}))
        else $error("dwell sum differs from period"); // R7

endmodule

// File: tb/tb_svm_dwell_calc.sv
`timescale 1ns/1ps
module tb_svm_dwell_calc;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [9:0]  theta;
    logic [15:0] k_mag;
    logic [15:0] ts;
    logic [1:0]  region;
    logic        auto_region;
    logic        out_vld;
    logic [15:0] ta;
    logic [15:0] tb;
    logic [15:0] tc;

    svm_dwell_calc dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (in_vld),
        .theta       (theta),
        .k_mag       (k_mag),
        .ts          (ts),
        .region      (region),
        .auto_region (auto_region),
        .out_vld     (out_vld),
        .ta          (ta),
        .tb          (tb),
        .tc          (tc)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    ta;
        int    tb;
        int    tc;
        int    tsv;
        int    due;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;
    bit   done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int qz(input real x, input int lim);
        int r;
        if (x <= 0.0) return 0;
        r = $rtoi(x + 0.5);
        return (r > lim) ? lim : r;
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // driver: compute expected dwell times from the equations, then present the sample
    task automatic drive(input int t, input int kc, input int tsv, input int rgc,
                         input bit au, input string tag);
        real  th, kq, g0, g1, g2, tt, fa, fb;
        int   r;
        exp_t e;
        th = $itor(t) * (PI / 3.0) / 1024.0;
        kq = $itor(kc) / 32768.0;
        tt = $itor(tsv);
        g0 = 2.0 * kq * $sin(th) * tt;
        g1 = 2.0 * kq * $sin(PI / 3.0 - th) * tt;
        g2 = 2.0 * kq * $sin(th + PI / 3.0) * tt;
        r  = rgc;
        if (au) begin
            if (g2 <= tt)      r = 0;
            else if (g1 >= tt) r = 1;
            else if (g0 >= tt) r = 3;
            else               r = 2;
        end
        case (r)
            0:       begin fa = g1;            fb = tt - g2; end
            1:       begin fa = 2.0 * tt - g2; fb = g0;      end
            2:       begin fa = tt - g0;       fb = g2 - tt; end
            default: begin fa = g0 - tt;       fb = g1;      end
        endcase
        e.ta  = qz(fa, tsv);
        e.tb  = qz(fb, tsv);
        e.tc  = (tsv - e.ta - e.tb > 0) ? tsv - e.ta - e.tb : 0;
        e.tsv = tsv;
        e.tag = tag;
        @(negedge clk);
        in_vld      = 1'b1;
        theta       = 10'(t);
        k_mag       = 16'(kc);
        ts          = 16'(tsv);
        region      = 2'(rgc);
        auto_region = au;
        e.due       = cyc + 4;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_vld) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected out_vld", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, "R1", "result cycle", cyc, e.due);
                    chk(absd(int'(ta), e.ta) <= 3, e.tag, "ta", int'(ta), e.ta);
                    chk(absd(int'(tb), e.tb) <= 3, e.tag, "tb", int'(tb), e.tb);
                    chk(absd(int'(tc), e.tc) <= 4, e.tag, "tc", int'(tc), e.tc);
                    if (int'(ta) + int'(tb) <= e.tsv)
                        chk(int'(ta) + int'(tb) + int'(tc) == e.tsv, "R7", "dwell sum",
                            int'(ta) + int'(tb) + int'(tc), e.tsv);
                end
            end else if (q.size() > 0 && q[0].due <= cyc) begin
                chk(1'b0, "R1", "missing out_vld", 0, 1);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        in_vld      = 1'b0;
        theta       = '0;
        k_mag       = '0;
        ts          = '0;
        region      = '0;
        auto_region = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(out_vld == 1'b0, "R9", "out_vld in reset", int'(out_vld), 0);
        chk(ta == 0 && tb == 0 && tc == 0, "R9", "dwell in reset", int'(ta) + int'(tb) + int'(tc), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: triangle 1, mid sector, then near the 60 degree end and with k = 0
        drive(512, 9830, 1000, 0, 1'b0, "R2");
        idle(3);
        drive(1023, 16384, 2000, 0, 1'b0, "R2");
        drive(700, 0, 800, 0, 1'b0, "R2");
        idle(6);
        // R3: triangle 2, including theta = 0
        drive(100, 29491, 2000, 1, 1'b0, "R3");
        drive(0, 26214, 2500, 1, 1'b0, "R3");
        idle(6);
        // R4: triangle 3
        drive(512, 19661, 1500, 2, 1'b0, "R4");
        drive(400, 21000, 3000, 2, 1'b0, "R4");
        idle(6);
        // R5: triangle 4
        drive(950, 29491, 3000, 3, 1'b0, "R5");
        drive(800, 27000, 1800, 3, 1'b0, "R5");
        idle(6);
        // R6: limits, large k in triangle 1, negative ta in triangle 4
        drive(512, 49152, 1000, 0, 1'b0, "R6");
        drive(300, 13107, 1200, 3, 1'b0, "R6");
        idle(6);
        // R8: finder picks the triangle; the region pin carries a wrong code
        drive(512, 9830, 1000, 3, 1'b1, "R8");
        drive(100, 29491, 2000, 0, 1'b1, "R8");
        drive(512, 19661, 1500, 0, 1'b1, "R8");
        drive(950, 29491, 3000, 1, 1'b1, "R8");
        idle(10);

        // R1: queue drained and strobe idle
        chk(q.size() == 0, "R1", "pending results", q.size(), 0);
        chk(out_vld == 1'b0, "R1", "idle out_vld", int'(out_vld), 0);

        done  = 1;
        rst_n = 1'b0;
        @(negedge clk);
        // R9: reset clears held results
        chk(out_vld == 1'b0 && ta == 0 && tb == 0 && tc == 0, "R9", "after reset",
            int'(ta) + int'(tb) + int'(tc) + int'(out_vld), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule